// File: doc/BRIEF.md
# Dual-Axis Multirate Periodic Voltage Controller

This block regulates the output voltage of a three-phase inverter in the rotating two-axis frame. It does this for the direct and quadrature axes at once, using two identical and independent copies of the same datapath. On each fast sample strobe it takes a signed reference and a signed measurement for each axis. It forms the error and returns one saturated control word per axis.

Each control word is the sum of two terms:
- A two-tap predictive proportional-derivative term. It runs on every fast strobe and uses only the two previous errors.
- A periodic-disturbance term. It runs at half the strobe rate, on every second strobe, and repeats its own output one half fundamental period later. It adds a scaled error sample taken from one half period back, moved forward by a small phase advance. Its recursion has only unit coefficients, so nothing pulls the error toward a constant offset. Between its updates the last value is held.

The block sits between the frame transform of the measured voltages and the modulator. Its gains arrive as live signed inputs.

Top module: `imc_voltage_ctrl`

## Requirements
- R1: For each axis the error is reference minus measurement, kept 17 bits wide, so a difference of two 16-bit values never wraps.
- R2: The fast term is uc(k) = floor((K1·e(k−1) + K2·e(k−2)) / 2^14). The gains are signed 16-bit with 14 fraction bits (nominal K1 = 1966 ≈ 0.12, K2 = −1311 ≈ −0.08). The error of the current strobe has no effect on the word produced for that strobe.
- R3: After reset the strobes count from 0. Odd-numbered strobes (the 2nd, 4th, …) are slow updates, and the slow error sample es(m) is the error at strobe 2m+1.
- R4: On slow update m, uim(m) = sat16(floor(KIM·es(m−21+A) / 2^14) + uim(m−21)). Here 21 is half of the 42 slow samples per fundamental period, the advance A defaults to 1, and KIM is signed Q2.14 (nominal 16384 = 1.0). History entries older than the reset read as zero.
- R5: On a strobe that is not a slow update, the most recent uim is reused unchanged. Before the first slow update it is zero.
- R6: Each axis output is sat16(uc + uim). It clamps to 32767 or −32768 and never wraps.
- R7: The valid output is high for exactly the one clock after each strobe clock. The control words change only on that clock and hold their value between strobes.
- R8: A synchronous reset clears the outputs, the valid flag, all error and output histories, and the strobe phase.
- R9: The two axes share no state. An axis whose error stays zero since reset outputs zero, whatever the other axis does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Fast sample strobe, one clock wide |
| ref_d_i | input | 16 | Direct-axis reference, signed |
| ref_q_i | input | 16 | Quadrature-axis reference, signed |
| meas_d_i | input | 16 | Direct-axis measured voltage, signed |
| meas_q_i | input | 16 | Quadrature-axis measured voltage, signed |
| k1_i | input | 16 | Gain on the previous error, signed Q2.14 |
| k2_i | input | 16 | Gain on the error two strobes back, signed Q2.14 |
| kim_i | input | 16 | Periodic-term gain, signed Q2.14 |
| ctl_d_o | output | 16 | Direct-axis control word, signed |
| ctl_q_o | output | 16 | Quadrature-axis control word, signed |
| ctl_vld_o | output | 1 | High on the clock after each strobe |

## Verification
The bound checker watches the timing contract on every clock:
- valid follows each strobe by exactly one clock and appears at no other time;
- both control words stay still between strobes;
- a reset clock leaves zeros behind.

The arithmetic can only be shown by the bench's scenarios, which compare each word against a model of the equations:
- the missing feed-through of the current error;
- which strobes are slow updates;
- the half-period recursion with its phase advance once the history buffers wrap;
- clamping under large gains;
- the cleared history and strobe phase after a reset in the middle of a run.

// File: rtl/imc_pkg.sv
package imc_pkg;

    localparam int unsigned DEF_DATA_W        = 16;
    localparam int unsigned DEF_GAIN_W        = 16;
    localparam int unsigned DEF_GAIN_FRAC     = 14;
    localparam int unsigned DEF_SLOW_PER_FUND = 42;
    localparam int unsigned DEF_ADVANCE       = 1;
    localparam int unsigned NUM_AXES          = 2;

    // Position of a fast strobe inside its slow period.
    typedef enum logic {
        PH_LEAD = 1'b0,
        PH_SLOW = 1'b1
    } tick_phase_e;

endpackage

// File: rtl/imc_pd_term.sv
module imc_pd_term #(
    parameter int unsigned DATA_W    = imc_pkg::DEF_DATA_W,
    parameter int unsigned GAIN_W    = imc_pkg::DEF_GAIN_W,
    parameter int unsigned GAIN_FRAC = imc_pkg::DEF_GAIN_FRAC
) (
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic                              tick_i,
    input  logic signed [DATA_W:0]            err_i,
    input  logic signed [GAIN_W-1:0]          k1_i,
    input  logic signed [GAIN_W-1:0]          k2_i,
    output logic signed [DATA_W+GAIN_W+1:0]   pd_o
);

    localparam int unsigned ERR_W = DATA_W + 1;
    localparam int unsigned ACC_W = DATA_W + GAIN_W + 2;

    typedef struct packed {
        logic [ERR_W-1:0] e1;   // error one strobe back
        logic [ERR_W-1:0] e2;   // error two strobes back
    } pd_state_t;

    pd_state_t st_d, st_q;

    logic signed [ACC_W-1:0] prod1, prod2, acc;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.e1 = err_i;
            st_d.e2 = st_q.e1;
        end
        prod1 = ACC_W'(k1_i) * ACC_W'($signed(st_q.e1));
        prod2 = ACC_W'(k2_i) * ACC_W'($signed(st_q.e2));
        acc   = prod1 + prod2;
        pd_o  = acc >>> GAIN_FRAC;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/imc_periodic_term.sv
module imc_periodic_term #(
    parameter int unsigned DATA_W    = imc_pkg::DEF_DATA_W,
    parameter int unsigned GAIN_W    = imc_pkg::DEF_GAIN_W,
    parameter int unsigned GAIN_FRAC = imc_pkg::DEF_GAIN_FRAC,
    parameter int unsigned DEPTH     = imc_pkg::DEF_SLOW_PER_FUND / 2,
    parameter int unsigned ADVANCE   = imc_pkg::DEF_ADVANCE
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     slow_i,
    input  logic signed [DATA_W:0]   err_i,
    input  logic signed [GAIN_W-1:0] kim_i,
    output logic signed [DATA_W-1:0] uim_o
);

    localparam int unsigned ERR_W = DATA_W + 1;
    localparam int unsigned ACC_W = DATA_W + GAIN_W + 2;
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic signed [ACC_W-1:0] MAX_W =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_W =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DEPTH-1:0][ERR_W-1:0]  err_mem;  // slow error samples
        logic [DEPTH-1:0][DATA_W-1:0] out_mem;  // past periodic outputs
        logic [PTR_W-1:0]             ptr;      // oldest slot, next write
        logic [DATA_W-1:0]            held;     // last periodic output
    } im_state_t;

    im_state_t st_d, st_q;

    logic [PTR_W:0]           rd_sum;
    logic [PTR_W-1:0]         rd_idx;
    logic signed [ACC_W-1:0]  scaled, upd_wide;
    logic signed [DATA_W-1:0] upd;

    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
        if (v > MAX_W) begin
            return MAX_W[DATA_W-1:0];
        end else if (v < MIN_W) begin
            return MIN_W[DATA_W-1:0];
        end
        return v[DATA_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        // The slot ADVANCE past the oldest holds the sample from DEPTH-ADVANCE updates back.
        rd_sum = {1'b0, st_q.ptr} + (PTR_W+1)'(ADVANCE);
        if (rd_sum >= (PTR_W+1)'(DEPTH)) begin
            rd_idx = PTR_W'(rd_sum - (PTR_W+1)'(DEPTH));
        end else begin
            rd_idx = PTR_W'(rd_sum);
        end
        scaled   = (ACC_W'(kim_i) * ACC_W'($signed(st_q.err_mem[rd_idx]))) >>> GAIN_FRAC;
        upd_wide = scaled + ACC_W'($signed(st_q.out_mem[st_q.ptr]));
        upd      = clamp(upd_wide);
        if (slow_i) begin
            st_d.err_mem[st_q.ptr] = err_i;
            st_d.out_mem[st_q.ptr] = upd;
            st_d.held              = upd;
            if (st_q.ptr == PTR_W'(DEPTH - 1)) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        uim_o = slow_i ? upd : $signed(st_q.held);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/imc_axis.sv
module imc_axis #(
    parameter int unsigned DATA_W    = imc_pkg::DEF_DATA_W,
    parameter int unsigned GAIN_W    = imc_pkg::DEF_GAIN_W,
    parameter int unsigned GAIN_FRAC = imc_pkg::DEF_GAIN_FRAC,
    parameter int unsigned DEPTH     = imc_pkg::DEF_SLOW_PER_FUND / 2,
    parameter int unsigned ADVANCE   = imc_pkg::DEF_ADVANCE
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     tick_i,
    input  logic                     slow_i,
    input  logic signed [DATA_W-1:0] ref_i,
    input  logic signed [DATA_W-1:0] meas_i,
    input  logic signed [GAIN_W-1:0] k1_i,
    input  logic signed [GAIN_W-1:0] k2_i,
    input  logic signed [GAIN_W-1:0] kim_i,
    output logic signed [DATA_W-1:0] ctl_o
);

    localparam int unsigned ERR_W = DATA_W + 1;
    localparam int unsigned ACC_W = DATA_W + GAIN_W + 2;
    localparam logic signed [ACC_W-1:0] MAX_W =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_W =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ERR_W-1:0]  err;
    logic signed [ACC_W-1:0]  pd_w, sum_w;
    logic signed [DATA_W-1:0] uim_w;

    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
        if (v > MAX_W) begin
            return MAX_W[DATA_W-1:0];
        end else if (v < MIN_W) begin
            return MIN_W[DATA_W-1:0];
        end
        return v[DATA_W-1:0];
    endfunction

    assign err = ERR_W'(ref_i) - ERR_W'(meas_i);

    imc_pd_term #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_pd (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_i),
        .err_i  (err),
        .k1_i   (k1_i),
        .k2_i   (k2_i),
        .pd_o   (pd_w)
    );

    imc_periodic_term #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .DEPTH     (DEPTH),
        .ADVANCE   (ADVANCE)
    ) u_im (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .slow_i (slow_i),
        .err_i  (err),
        .kim_i  (kim_i),
        .uim_o  (uim_w)
    );

    always_comb begin
        sum_w = pd_w + ACC_W'(uim_w);
        ctl_o = clamp(sum_w);
    end

endmodule

// File: rtl/imc_voltage_ctrl.sv
module imc_voltage_ctrl #(
    parameter int unsigned DATA_W        = imc_pkg::DEF_DATA_W,
    parameter int unsigned GAIN_W        = imc_pkg::DEF_GAIN_W,
    parameter int unsigned GAIN_FRAC     = imc_pkg::DEF_GAIN_FRAC,
    parameter int unsigned SLOW_PER_FUND = imc_pkg::DEF_SLOW_PER_FUND,
    parameter int unsigned ADVANCE       = imc_pkg::DEF_ADVANCE
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     tick_i,
    input  logic signed [DATA_W-1:0] ref_d_i,
    input  logic signed [DATA_W-1:0] ref_q_i,
    input  logic signed [DATA_W-1:0] meas_d_i,
    input  logic signed [DATA_W-1:0] meas_q_i,
    input  logic signed [GAIN_W-1:0] k1_i,
    input  logic signed [GAIN_W-1:0] k2_i,
    input  logic signed [GAIN_W-1:0] kim_i,
    output logic signed [DATA_W-1:0] ctl_d_o,
    output logic signed [DATA_W-1:0] ctl_q_o,
    output logic                     ctl_vld_o
);

    import imc_pkg::*;

    localparam int unsigned HALF = SLOW_PER_FUND / 2;
    localparam int unsigned NAX  = NUM_AXES;

    typedef struct packed {
        tick_phase_e                  phase;
        logic                         vld;
        logic [NAX-1:0][DATA_W-1:0]   ctl;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                     slow;
    logic signed [DATA_W-1:0] ref_a  [NAX];
    logic signed [DATA_W-1:0] meas_a [NAX];
    logic signed [DATA_W-1:0] ctl_w  [NAX];

    assign ref_a[0]  = ref_d_i;
    assign ref_a[1]  = ref_q_i;
    assign meas_a[0] = meas_d_i;
    assign meas_a[1] = meas_q_i;
    assign slow      = tick_i && (st_q.phase == PH_SLOW);

    for (genvar ax = 0; ax < NAX; ax++) begin : g_axis
        imc_axis #(
            .DATA_W    (DATA_W),
            .GAIN_W    (GAIN_W),
            .GAIN_FRAC (GAIN_FRAC),
            .DEPTH     (HALF),
            .ADVANCE   (ADVANCE)
        ) u_axis (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .tick_i (tick_i),
            .slow_i (slow),
            .ref_i  (ref_a[ax]),
            .meas_i (meas_a[ax]),
            .k1_i   (k1_i),
            .k2_i   (k2_i),
            .kim_i  (kim_i),
            .ctl_o  (ctl_w[ax])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = tick_i;
        if (tick_i) begin
            st_d.phase = (st_q.phase == PH_SLOW) ? PH_LEAD : PH_SLOW;
            for (int ax = 0; ax < NAX; ax++) begin
                st_d.ctl[ax] = ctl_w[ax];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_d_o   = $signed(st_q.ctl[0]);
    assign ctl_q_o   = $signed(st_q.ctl[1]);
    assign ctl_vld_o = st_q.vld;

endmodule

// File: rtl/imc_voltage_ctrl_chk.sv
module imc_voltage_ctrl_chk #(
    parameter int unsigned DATA_W = imc_pkg::DEF_DATA_W
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     tick_i,
    input logic signed [DATA_W-1:0] ctl_d_o,
    input logic signed [DATA_W-1:0] ctl_q_o,
    input logic                     ctl_vld_o
);

    // R7: valid answers every strobe one clock later
    a_r7_vld_after_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> ctl_vld_o);

    // R7: valid never appears without a strobe
    a_r7_no_spurious_vld: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> !ctl_vld_o);

    // R7: control words hold between strobes
    a_r7_hold_words: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> ($stable(ctl_d_o) && $stable(ctl_q_o)));

    // R8: a reset clock leaves cleared outputs
    a_r8_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (ctl_d_o == '0 && ctl_q_o == '0 && !ctl_vld_o));

endmodule

bind imc_voltage_ctrl imc_voltage_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick_i),
    .ctl_d_o   (ctl_d_o),
    .ctl_q_o   (ctl_q_o),
    .ctl_vld_o (ctl_vld_o)
);

// File: tb/test_imc_voltage_ctrl.sv
`timescale 1ns/1ps
module test_imc_voltage_ctrl;

    localparam int HALF = 21;
    localparam int ADV  = 1;
    localparam int GF   = 14;
    localparam int MAXM = 256;
    localparam int NV   = 12;
    // stimulus rows: ref_d, meas_d, ref_q, meas_q
    localparam int VEC [0:NV-1][0:3] = '{
        '{ 1000,     0,  -500,   200},
        '{ 2000,   500,   300,   300},
        '{-3000,  1200,  4000, -4000},
        '{32767,-32768,     0,     0},
        '{-32768, 32767,  100,   -50},
        '{  700,   650, -1234,  5678},
        '{    0,     0,     0,     0},
        '{ 1500, -1500,  2500,  2400},
        '{-8000, -7000, 12000,  9000},
        '{  123,   -77,   -33,    44},
        '{ 9999,     1, -9999,    -1},
        '{  -42,    42,    42,   -42}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic signed [15:0] ref_d = '0, ref_q = '0, meas_d = '0, meas_q = '0;
    logic signed [15:0] k1 = '0, k2 = '0, kim = '0;
    logic signed [15:0] ctl_d, ctl_q;
    logic ctl_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    longint e1 [2], e2 [2], held [2];
    longint es_h [2][0:MAXM-1];
    longint um_h [2][0:MAXM-1];
    int tick_k;
    longint exp_v [2];

    always #2.5 clk = ~clk;

    imc_voltage_ctrl i_imc_voltage_ctrl (
        .clk_i(clk), .rst_i(rst), .tick_i(tick),
        .ref_d_i(ref_d), .ref_q_i(ref_q), .meas_d_i(meas_d), .meas_q_i(meas_q),
        .k1_i(k1), .k2_i(k2), .kim_i(kim),
        .ctl_d_o(ctl_d), .ctl_q_o(ctl_q), .ctl_vld_o(ctl_vld)
    );

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 2; a++) begin
            e1[a] = 0; e2[a] = 0; held[a] = 0;
            for (int i = 0; i < MAXM; i++) begin
                es_h[a][i] = 0; um_h[a][i] = 0;
            end
        end
        tick_k = 0;
    endtask

    task automatic model_step(input longint rd, md, rq, mq);
        longint e, uc, src, prv;
        int m;
        for (int a = 0; a < 2; a++) begin
            e  = (a == 0) ? rd - md : rq - mq;                          // R1
            uc = (longint'(k1) * e1[a] + longint'(k2) * e2[a]) >>> GF;  // R2
            if (tick_k % 2 == 1) begin                                  // R3
                m = (tick_k - 1) / 2;
                es_h[a][m] = e;
                src = (m - HALF + ADV >= 0) ? es_h[a][m - HALF + ADV] : 0;
                prv = (m - HALF >= 0) ? um_h[a][m - HALF] : 0;
                um_h[a][m] = sat16(((longint'(kim) * src) >>> GF) + prv); // R4
                held[a] = um_h[a][m];
            end
            exp_v[a] = sat16(uc + held[a]);                             // R5 R6
            e2[a] = e1[a];
            e1[a] = e;
        end
        tick_k++;
    endtask

    task automatic do_tick(input longint rd, md, rq, mq, input string tag);
        longint hd, hq;
        @(negedge clk);
        ref_d = 16'(rd); meas_d = 16'(md); ref_q = 16'(rq); meas_q = 16'(mq);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_step(rd, md, rq, mq);
        check({tag, " d-axis"}, ctl_d, exp_v[0]);
        check({tag, " q-axis"}, ctl_q, exp_v[1]);
        check("R7 valid after strobe", ctl_vld, 1);
        hd = ctl_d; hq = ctl_q;
        @(negedge clk);
        check("R7 valid drops", ctl_vld, 0);
        check("R7 hold d", ctl_d, hd);
        check("R7 hold q", ctl_q, hq);
    endtask

    task automatic set_default_gains();
        k1 = 16'sd1966; k2 = -16'sd1311; kim = 16'sd16384;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        set_default_gains();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset d", ctl_d, 0);
        check("R8 reset q", ctl_q, 0);
        check("R8 reset valid", ctl_vld, 0);
        rst = 1'b0;

        // R2: a large current error does not feed through on its own strobe
        do_tick(20000, -10000, -20000, 10000, "R2 R1 no feedthrough");
        check("R2 first word zero", ctl_d, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_tick(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], "R1 R2 R3 R9 table");
        end

        // long periodic run: recursion wraps the half-period buffers
        for (int i = 0; i < 110; i++) begin
            do_tick(((i * 1237) % 8000) - 4000, ((i * 311) % 900) - 450,
                    3000 - ((i * 977) % 6000), (i % 7) * 60, "R4 R5 R6 periodic");
        end

        // saturation under large gains
        k1 = 16'sd32767; k2 = 16'sd0; kim = 16'sd32767;
        for (int i = 0; i < 8; i++) begin
            do_tick(30000, -30000, -30000, 30000, "R6 clamp");
        end
        check("R6 positive clamp", ctl_d, 32767);
        check("R6 negative clamp", ctl_q, -32768);

        // mid-run reset clears histories and phase
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 mid-run reset d", ctl_d, 0);
        check("R8 mid-run reset q", ctl_q, 0);
        check("R8 mid-run reset valid", ctl_vld, 0);
        model_reset();
        set_default_gains();
        for (int i = 0; i < 50; i++) begin
            do_tick(((i * 2111) % 10000) - 5000, (i * 37) % 500,
                    (i * 401) % 3000, (i * 401) % 3000, "R8 R3 after reset");
            check("R9 quiet q-axis stays zero", ctl_q, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule